// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Sequencer

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host makes single-beat requests over a valid/ready handshake, carrying an address, write data and a write flag. The block turns each request into a properly timed cycle on the RAM pins: a 17-bit address, an 8-bit bidirectional data bus, one active-low and one active-high chip select, an active-low output enable and an active-low write enable. For a read, the byte is returned on a registered data output together with a one-cycle valid pulse.

All RAM timing is expressed in clock cycles through parameters: address setup ahead of the write strobe, write strobe width, data setup before the strobe rises, read access time, the shortest allowed selection (the RAM cycle time), a bus turnaround gap after a read, and a recovery lockout. Writes are controlled by the write strobe: both selects are held active around it, the output enable stays high, and the address never moves while the chip is selected.

A low-power retention input parks the RAM by pulling the active-high select low. When the input is released, the block holds the host off for a recovery count of cycles before it accepts new work. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `sram_bus_ctl`

## Requirements
- R1: While reset is held and in the cycles after it is released, the write strobe, output enable and active-low select are all high, the active-high select is high, no read response is given, and the host sees ready within four cycles of release.
- R2: A write drives the data bus from the setup phase to the end of the cycle, holds the write strobe low with both selects active and the output enable high for max(WR_PULSE_CYC, DATA_SETUP_CYC) cycles, and the stored byte is the one presented with the request.
- R3: The RAM address is stable for every cycle the active-low select is low.
- R4: A read holds the write strobe high and the output enable low for max(RD_ACCESS_CYC, MIN_CYCLE_CYC) cycles, samples the bus at the end of the last of them, and then presents the byte with rsp_valid high for exactly one cycle.
- R5: Each selection of the RAM (active-low select low) lasts at least MIN_CYCLE_CYC cycles, for reads and for writes.
- R6: A write that follows a read leaves at least TURN_CYC + 2 deselected cycles between the two selections; a write that follows a write needs only one.
- R7: req_ready is low for the whole of an access; an isolated read keeps it low for the read length plus one cycle after the accepting edge.
- R8: While ret_req is high and the block is idle, the active-high select is low, the active-low select is high and req_ready is low; requests made then start no RAM activity.
- R9: After ret_req falls, req_ready returns exactly RECOV_CYC clock edges later, and requests held during the lockout start no RAM activity before then.
- R10: When ret_req and a request arrive together at an idle block, retention wins; an access already accepted runs to completion (including its read response) before the chip is parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Registered read data |
| ret_req | input | 1 | Retention (low-power park) request |
| ram_addr | output | 17 | RAM address |
| ram_dq | inout | 8 | RAM bidirectional data |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_ce | output | 1 | RAM select, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |

## Verification
The properties assume that the host only counts a request as taken on an edge where req_ready is high, that request fields are sampled once at that edge, and that ret_req is a level the host holds for several cycles rather than a glitch. The stimulus keeps to this by changing every input on the falling clock edge, waiting for ready before raising req_valid and dropping it on the next falling edge. A behavioural RAM on the bench drives a poison byte until the read has been open for the access time and only commits a write whose strobe width and data stability meet the minimums, so short timing shows up as wrong data or a counted violation.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_DONE    = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_PULSE   = 3'd4,
    ST_WR_END     = 3'd5,
    ST_TURNAROUND = 3'd6,
    ST_RETENTION  = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic ce;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } bus_ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_bus_pkg::*;
#(
  parameter int RD_ACCESS_CYC  = 18,
  parameter int WR_SETUP_CYC   = 1,
  parameter int WR_PULSE_CYC   = 13,
  parameter int DATA_SETUP_CYC = 9,
  parameter int MIN_CYCLE_CYC  = 18,
  parameter int TURN_CYC       = 1,
  parameter int RECOV_CYC      = 1250000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     req_write,
  input  logic     ret_req,
  output logic     req_ready,
  output logic     accept,
  output logic     capture,
  output logic     rsp_valid,
  output bus_ctl_t ctl
);
  // Derived phase lengths, each at least one cycle
  localparam int RD_LEN    = imax(imax(RD_ACCESS_CYC, MIN_CYCLE_CYC), 1);
  localparam int SETUP_LEN = imax(WR_SETUP_CYC, 1);
  localparam int PULSE_LEN = imax(imax(WR_PULSE_CYC, DATA_SETUP_CYC), 1);
  localparam int END_LEN   = imax(MIN_CYCLE_CYC - SETUP_LEN - PULSE_LEN, 1);
  localparam int TURN_LEN  = imax(TURN_CYC, 1);
  localparam int RECOV_LEN = imax(RECOV_CYC, 1);
  localparam int MAX_LEN   = imax(imax(imax(RD_LEN, RECOV_LEN), imax(PULSE_LEN, END_LEN)),
                                  imax(SETUP_LEN, TURN_LEN));
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_LEN - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_LEN - 1);
  localparam logic [CNT_W-1:0] END_LD   = CNT_W'(END_LEN - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_LEN - 1);
  localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_LEN - 1);
  localparam bit               USE_TURN = (TURN_CYC > 0);

  seq_state_e       state_q, state_d;
  logic             rd_last_q, rd_last_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign req_ready = (state_q == ST_IDLE) && !ret_req;
  assign accept    = req_valid && req_ready;
  assign capture   = (state_q == ST_RD_ACCESS) && tmr_done;
  assign rsp_valid = (state_q == ST_RD_DONE);

  // Next-state and phase timer load
  always_comb begin
    state_d   = state_q;
    rd_last_d = rd_last_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_req) begin
          state_d  = ST_RETENTION;
          tmr_load = 1'b1;
          tmr_val  = RECOV_LD;
        end else if (req_valid) begin
          tmr_load = 1'b1;
          if (!req_write) begin
            state_d = ST_RD_ACCESS;
            tmr_val = RD_LD;
          end else if (rd_last_q && USE_TURN) begin
            state_d = ST_TURNAROUND;
            tmr_val = TURN_LD;
          end else begin
            state_d = ST_WR_SETUP;
            tmr_val = SETUP_LD;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (tmr_done) state_d = ST_RD_DONE;
      end
      ST_RD_DONE: begin
        state_d   = ST_IDLE;
        rd_last_d = 1'b1;
      end
      ST_TURNAROUND: begin
        if (tmr_done) begin
          state_d  = ST_WR_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      ST_WR_SETUP: begin
        if (tmr_done) begin
          state_d  = ST_WR_PULSE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) begin
          state_d  = ST_WR_END;
          tmr_load = 1'b1;
          tmr_val  = END_LD;
        end
      end
      ST_WR_END: begin
        if (tmr_done) begin
          state_d   = ST_IDLE;
          rd_last_d = 1'b0;
        end
      end
      ST_RETENTION: begin
        if (ret_req) begin
          tmr_load = 1'b1;
          tmr_val  = RECOV_LD;
        end else if (tmr_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rd_last_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rd_last_q <= rd_last_d;
    end
  end

  // Pin strobes decoded from the state register
  always_comb begin
    ctl.ce_n  = 1'b1;
    ctl.ce    = 1'b1;
    ctl.oe_n  = 1'b1;
    ctl.we_n  = 1'b1;
    ctl.dq_oe = 1'b0;
    unique case (state_q)
      ST_RD_ACCESS: begin
        ctl.ce_n = 1'b0;
        ctl.oe_n = 1'b0;
      end
      ST_WR_SETUP, ST_WR_END: begin
        ctl.ce_n  = 1'b0;
        ctl.dq_oe = 1'b1;
      end
      ST_WR_PULSE: begin
        ctl.ce_n  = 1'b0;
        ctl.we_n  = 1'b0;
        ctl.dq_oe = 1'b1;
      end
      ST_RETENTION: ctl.ce = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // Address and write data change only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end

  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rdata_out = rdata_q;
endmodule

// File: rtl/sram_bus_ctl.sv
module sram_bus_ctl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8,
  parameter int RD_ACCESS_CYC  = 18,
  parameter int WR_SETUP_CYC   = 1,
  parameter int WR_PULSE_CYC   = 13,
  parameter int DATA_SETUP_CYC = 9,
  parameter int MIN_CYCLE_CYC  = 18,
  parameter int TURN_CYC       = 1,
  parameter int RECOV_CYC      = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ret_req,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [DATA_W-1:0] ram_dq,
  output logic              ram_ce_n,
  output logic              ram_ce,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  logic              rst_n_i;
  logic              accept, capture;
  logic              dq_oe;
  logic [DATA_W-1:0] wdata;
  bus_ctl_t          ctl;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  sram_seq #(
    .RD_ACCESS_CYC  (RD_ACCESS_CYC),
    .WR_SETUP_CYC   (WR_SETUP_CYC),
    .WR_PULSE_CYC   (WR_PULSE_CYC),
    .DATA_SETUP_CYC (DATA_SETUP_CYC),
    .MIN_CYCLE_CYC  (MIN_CYCLE_CYC),
    .TURN_CYC       (TURN_CYC),
    .RECOV_CYC      (RECOV_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .ret_req   (ret_req),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .rsp_valid (rsp_valid),
    .ctl       (ctl)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .bus_in    (ram_dq),
    .addr_out  (ram_addr),
    .wdata_out (wdata),
    .rdata_out (rsp_rdata)
  );

  assign dq_oe    = ctl.dq_oe;
  assign ram_ce_n = ctl.ce_n;
  assign ram_ce   = ctl.ce;
  assign ram_oe_n = ctl.oe_n;
  assign ram_we_n = ctl.we_n;
  assign ram_dq   = dq_oe ? wdata : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_bus_ctl_chk.sv
module sram_bus_ctl_chk #(
  parameter int ADDR_W    = 17,
  parameter int PULSE_MIN = 13,
  parameter int SEL_MIN   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_ce,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              dq_oe
);
  logic [23:0] we_lo_cnt, sel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_lo_cnt <= '0;
    else if (!ram_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
    else               we_lo_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_cnt <= '0;
    else if (!ram_ce_n) sel_cnt <= sel_cnt + 1'b1;
    else               sel_cnt <= '0;
  end

  // R2
  strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (ram_oe_n && !ram_ce_n && ram_ce && dq_oe));
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_lo_cnt >= 24'(PULSE_MIN)));
  // R2
  drive_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ram_oe_n);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));
  // R4
  read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> ram_we_n);
  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R5
  sel_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_ce_n) |-> (sel_cnt >= 24'(SEL_MIN)));
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> !req_ready);
  // R8
  park_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce |-> (ram_ce_n && !req_ready));
endmodule

bind sram_bus_ctl sram_bus_ctl_chk #(
  .ADDR_W    (ADDR_W),
  .PULSE_MIN (WR_PULSE_CYC),
  .SEL_MIN   (MIN_CYCLE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ram_addr  (ram_addr),
  .ram_ce_n  (ram_ce_n),
  .ram_ce    (ram_ce),
  .ram_oe_n  (ram_oe_n),
  .ram_we_n  (ram_we_n),
  .dq_oe     (dq_oe)
);

// File: tb/test_sram_bus_ctl.sv
module test_sram_bus_ctl;
  localparam int AW     = 17;
  localparam int DW     = 8;
  localparam int RD     = 18;
  localparam int SU     = 1;
  localparam int PW     = 13;
  localparam int DSU    = 9;
  localparam int MINC   = 18;
  localparam int TA     = 1;
  localparam int RECOV  = 40;
  localparam int RD_NEED = 18; // 72 ns at 4 ns per cycle

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ram_addr;
  wire  [DW-1:0] ram_dq;
  logic          ram_ce_n, ram_ce, ram_oe_n, ram_we_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_bus_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_ACCESS_CYC(RD), .WR_SETUP_CYC(SU),
    .WR_PULSE_CYC(PW), .DATA_SETUP_CYC(DSU), .MIN_CYCLE_CYC(MINC),
    .TURN_CYC(TA), .RECOV_CYC(RECOV)
  ) i_sram_bus_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
    .ram_addr(ram_addr), .ram_dq(ram_dq), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:8]} ^ 8'h5A;
  endfunction

  // ---------------- behavioural RAM ----------------
  logic [7:0] mem [int];
  wire sel   = !ram_ce_n && ram_ce;
  wire rd_on = sel && !ram_oe_n && ram_we_n;
  wire wr_on = sel && !ram_we_n;
  int  rd_cnt = 0;
  logic [7:0] rd_val_q = 8'h00;
  int  wp_cnt = 0, ds_cnt = 0, viol_wr = 0, viol_addr = 0;
  bit  wr_prev = 1'b0, sel_prev = 1'b0;
  logic [AW-1:0] last_a = '0;
  logic [7:0]    last_d = '0;

  assign ram_dq = rd_on ? ((rd_cnt + 1 >= RD_NEED) ? rd_val_q : 8'hA5) : 8'hzz;

  always @(posedge clk) begin
    if (sel && sel_prev && ram_addr != last_a) viol_addr++;
    if (wr_on) begin
      wp_cnt = wr_prev ? wp_cnt + 1 : 1;
      ds_cnt = (wr_prev && ram_dq == last_d) ? ds_cnt + 1 : 1;
      if (!ram_oe_n) viol_wr++;
      last_d = ram_dq;
    end else if (wr_prev) begin
      if (wp_cnt >= PW && ds_cnt >= DSU) mem[int'(last_a)] = last_d;
      else viol_wr++;
    end
    wr_prev  = wr_on;
    sel_prev = sel;
    last_a   = ram_addr;
    rd_cnt   <= rd_on ? rd_cnt + 1 : 0;
    rd_val_q <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : init_val(ram_addr);
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q[$];
  logic [7:0] shadow [int];
  bit rsp_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      chk(!rsp_prev, "R4 rsp_valid one-cycle pulse", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected response", rsp_rdata, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R4/R2 read data", rsp_rdata, e);
      end
    end
    rsp_prev = rsp_valid;
  end

  // ---------------- selection burst monitor ----------------
  int  run_len = 0, gap_len = 0, sel_cycles = 0;
  bit  in_sel = 1'b0, cur_rd = 1'b0, prev_rd = 1'b0, have_prev = 1'b0;
  bit  gap_ww_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_ce_n) begin
        sel_cycles++;
        if (!in_sel) begin
          cur_rd = !ram_oe_n;
          if (have_prev && !cur_rd && prev_rd)
            chk(gap_len >= TA + 2, "R6 read-to-write gap", gap_len, TA + 2);
          if (have_prev && !cur_rd && !prev_rd && gap_len == 1) gap_ww_seen = 1'b1;
          run_len = 1;
        end else run_len++;
        in_sel = 1'b1;
      end else begin
        if (in_sel) begin
          chk(run_len >= MINC, "R5 selection length", run_len, MINC);
          prev_rd   = cur_rd;
          have_prev = 1'b1;
          gap_len   = 0;
        end
        gap_len++;
        in_sel = 1'b0;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int s0;
    repeat (3) @(negedge clk);
    // R1: strobes inactive under reset
    chk(ram_ce_n && ram_oe_n && ram_we_n && ram_ce, "R1 strobes in reset",
        {ram_ce_n, ram_ce, ram_oe_n, ram_we_n}, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after release", req_ready, 1);
    chk(!rsp_valid && ram_ce_n && ram_oe_n && ram_we_n && ram_ce, "R1 idle pins",
        {rsp_valid, ram_ce_n, ram_ce, ram_oe_n, ram_we_n}, 5'h0F);

    // R2/R4: writes then reads, boundary addresses and patterns
    issue(1'b1, 17'h00000, 8'h55);
    issue(1'b1, 17'h1FFFF, 8'hFF);
    issue(1'b1, 17'h0AAAA, 8'h00);
    issue(1'b1, 17'h0AAAA, 8'hC3);          // last write wins
    issue(1'b0, 17'h00000, 8'h00);
    issue(1'b0, 17'h1FFFF, 8'h00);
    issue(1'b0, 17'h0AAAA, 8'h00);
    issue(1'b0, 17'h12345, 8'h00);          // never written
    // R6: read followed by write, then read back
    issue(1'b1, 17'h12345, 8'h3C);
    issue(1'b0, 17'h12345, 8'h00);
    drain();
    chk(gap_ww_seen, "R6 write-to-write gap of one", gap_ww_seen, 1);

    // R7: isolated read keeps ready low for read length plus one
    issue(1'b0, 17'h00001, 8'h00);
    n = 1;
    while (!req_ready) begin @(negedge clk); n++; end
    chk(n == RD + 2, "R7 busy span of a read", n, RD + 2);
    drain();

    // R8/R10: retention and request together, retention wins
    @(negedge clk);
    ret_req   = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h99;
    s0 = sel_cycles;
    @(negedge clk);
    chk(!ram_ce && ram_ce_n, "R10 retention wins over request", {ram_ce, ram_ce_n}, 2'b01);
    repeat (5) @(negedge clk);
    chk(!ram_ce && ram_ce_n && !req_ready, "R8 parked pins",
        {ram_ce, ram_ce_n, req_ready}, 3'b010);
    // R9: release and count edges until ready with a request held
    ret_req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ready && n < 10 * RECOV);
    chk(n == RECOV, "R9 recovery lockout length", n, RECOV);
    chk(sel_cycles == s0, "R8/R9 request ignored while parked", sel_cycles - s0, 0);
    shadow[32'h777] = 8'h99;                // accepted at the next edge
    @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 17'h00777, 8'h00);
    drain();

    // R10: access in flight completes before parking
    issue(1'b0, 17'h1FFFF, 8'h00);
    ret_req = 1'b1;
    @(negedge clk);
    chk(!ram_ce_n && ram_ce, "R10 in-flight read continues", {ram_ce_n, ram_ce}, 2'b01);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!ram_ce, "R10 parked after completion", ram_ce, 0);
    ret_req = 1'b0;
    repeat (RECOV + 2) @(negedge clk);
    chk(req_ready, "R9 ready after lockout", req_ready, 1);

    drain();
    // R2/R3: RAM model timing bookkeeping
    chk(viol_wr == 0, "R2 write strobe/data timing", viol_wr, 0);
    chk(viol_addr == 0, "R3 address stable while selected", viol_addr, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule